// File: doc/BRIEF.md
# Frequency-Change Watchdog with Recovery Lockout

This block supervises the output-frequency code of a programmable clock generator. Software writes a new frequency code through a small register port. If the watchdog is enabled, each real change of the code starts a countdown in units of an external tick. Software confirms the new setting by clearing the watchdog enable before the countdown expires. If it does not, the block assumes the new frequency left the system unable to run. It then fires a fixed-length system reset pulse, forces a recovery frequency code onto its output and refuses all further frequency writes.

The lockout stays in force until software writes the watchdog enable back to 0. That single write stops the timer, reloads the count and lifts the lock. A separate option makes the block also emit the reset pulse on every accepted frequency change, whether or not the watchdog times out.

Top module: `fcwd_top`

## Requirements
- R1: After reset the frequency output is 0, every control field (watchdog enable, timeout status, reset-on-change) reads 0 and the reset pulse output is low.
- R2: A write to the frequency register (address 0, code in bits [FREQ_W-1:0]) counts as a change only when the written code differs from the current one. Rewriting the current code neither starts nor restarts the countdown and does not raise a reset pulse.
- R3: With the watchdog enabled, a change loads the countdown with RELOAD. A timeout occurs on the RELOAD-th tick after the most recent change. A later change restarts the full count.
- R4: Writing 0 to the watchdog enable (control register, address 1, bit 0) stops the countdown, reloads it and releases the lockout. While the enable is 0, changes never start the countdown.
- R5: The timeout status (control bit 1) reads 1 after a timeout. Writing 1 to it clears it. Writing 0 to it leaves it unchanged. Clearing the status does not lift the lockout.
- R6: On timeout the frequency output takes the value RECOV_CODE in the next cycle, the block enters lockout and a reset pulse starts.
- R7: During lockout, frequency register writes are ignored and the output stays at RECOV_CODE.
- R8: When reset-on-change (control bit 2) is 1, every accepted frequency change starts a reset pulse. When it is 0, a change starts no pulse.
- R9: A reset pulse is high for exactly PULSE_LEN (16) clock cycles after the triggering edge. A new trigger during a pulse restarts the full length.
- R10: Reads return the current frequency code zero-extended at address 0. At address 1 they return {roc, status, enable} in bits [2:0] with the upper bits 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 frequency, 1 control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| tick | input | 1 | Countdown time base, one count per cycle it is high |
| freq_sel | output | FREQ_W | Frequency code driven to the clock generator |
| sys_rst_pulse | output | 1 | System reset pulse |

## Verification
A table of register writes and tick bursts takes the block through several patterns. One is a change followed by a rewrite of the same code, which separates "rewrite restarts the count" from "rewrite is ignored". Another is two distinct changes spaced less than RELOAD ticks apart, which separates a restarting count from a running one. A third is a frequency write during lockout, followed by status clears with bit 1 at 0 and at 1 and then an enable clear; this tells status handling apart from lock release. Directed tests count the exact reset pulse width and show that a mid-pulse retrigger yields 16 further cycles, not the remaining 6.

// File: rtl/fcwd_pkg.sv
package fcwd_pkg;
  localparam int DATA_W = 8;

  localparam logic ADDR_FREQ = 1'b0;
  localparam logic ADDR_CTL  = 1'b1;

  localparam int BIT_WDEN = 0;
  localparam int BIT_TOST = 1;
  localparam int BIT_ROC  = 2;

  typedef struct packed {
    logic roc;
    logic status;
    logic wd_en;
  } ctl_t;
endpackage

// File: rtl/fcwd_countdown.sv
module fcwd_countdown #(
  parameter int unsigned W          = 10,
  parameter logic [W-1:0] RELOAD_VAL = 10'd200
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm,
  input  logic         stop,
  input  logic         tick,
  output logic [W-1:0] count,
  output logic         armed,
  output logic         expire
);
  function automatic logic last_tick(input logic [W-1:0] c);
    return c == W'(1);
  endfunction

  function automatic logic [W-1:0] step_down(input logic [W-1:0] c);
    return c - W'(1);
  endfunction

  assign expire = armed && tick && last_tick(count) && !arm && !stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      count <= RELOAD_VAL;
    end else if (stop || expire) begin
      armed <= 1'b0;
      count <= RELOAD_VAL;
    end else if (arm) begin
      armed <= 1'b1;
      count <= RELOAD_VAL;
    end else if (armed && tick) begin
      count <= step_down(count);
    end
  end
endmodule

// File: rtl/fcwd_pulse.sv
module fcwd_pulse #(
  parameter int unsigned LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);
  localparam int unsigned CW = $clog2(LEN + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             remain <= '0;
    else if (trig)          remain <= CW'(LEN);
    else if (remain != '0)  remain <= remain - CW'(1);
  end

  assign pulse = remain != '0;
endmodule

// File: rtl/fcwd_top.sv
module fcwd_top
  import fcwd_pkg::*;
#(
  parameter int unsigned FREQ_W     = 4,
  parameter int unsigned RELOAD_W   = 10,
  parameter int unsigned RELOAD     = 200,
  parameter int unsigned RECOV_CODE = 10,
  parameter int unsigned PULSE_LEN  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tick,
  output logic [FREQ_W-1:0] freq_sel,
  output logic              sys_rst_pulse
);
  localparam logic [RELOAD_W-1:0] RELOAD_L = RELOAD[RELOAD_W-1:0];
  localparam logic [FREQ_W-1:0]   RECOV_L  = RECOV_CODE[FREQ_W-1:0];

  function automatic logic differs(input logic [FREQ_W-1:0] a, input logic [FREQ_W-1:0] b);
    return a != b;
  endfunction

  logic [FREQ_W-1:0]   freq_q;
  ctl_t                ctl_q;
  logic                locked_q;
  logic                wr_freq, wr_ctl;
  logic                freq_change, stop_req, timeout_evt, pulse_trig;
  logic                armed;
  logic [RELOAD_W-1:0] count;
  logic                unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:FREQ_W];

  assign wr_freq     = reg_wr && (reg_addr == ADDR_FREQ);
  assign wr_ctl      = reg_wr && (reg_addr == ADDR_CTL);
  assign freq_change = wr_freq && !locked_q && differs(reg_wdata[FREQ_W-1:0], freq_q);
  assign stop_req    = wr_ctl && !reg_wdata[BIT_WDEN];
  assign pulse_trig  = timeout_evt || (freq_change && ctl_q.roc);

  fcwd_countdown #(.W(RELOAD_W), .RELOAD_VAL(RELOAD_L)) u_countdown (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (freq_change && ctl_q.wd_en),
    .stop   (stop_req),
    .tick   (tick),
    .count  (count),
    .armed  (armed),
    .expire (timeout_evt)
  );

  fcwd_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .trig  (pulse_trig),
    .pulse (sys_rst_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_q   <= '0;
      ctl_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      if (timeout_evt)      freq_q <= RECOV_L;
      else if (freq_change) freq_q <= reg_wdata[FREQ_W-1:0];

      if (wr_ctl) begin
        ctl_q.wd_en <= reg_wdata[BIT_WDEN];
        ctl_q.roc   <= reg_wdata[BIT_ROC];
      end

      if (timeout_evt)                       ctl_q.status <= 1'b1;
      else if (wr_ctl && reg_wdata[BIT_TOST]) ctl_q.status <= 1'b0;

      if (stop_req)         locked_q <= 1'b0;
      else if (timeout_evt) locked_q <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_CTL) begin
      reg_rdata[BIT_WDEN] = ctl_q.wd_en;
      reg_rdata[BIT_TOST] = ctl_q.status;
      reg_rdata[BIT_ROC]  = ctl_q.roc;
    end else begin
      reg_rdata[FREQ_W-1:0] = freq_q;
    end
  end

  assign freq_sel = freq_q;
endmodule

// File: rtl/fcwd_checks.sv
module fcwd_checks #(
  parameter int unsigned FREQ_W     = 4,
  parameter int unsigned RELOAD_W   = 10,
  parameter int unsigned RELOAD     = 200,
  parameter int unsigned RECOV_CODE = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic [FREQ_W-1:0]   freq_sel,
  input logic                sys_rst_pulse,
  input logic                timeout_evt,
  input logic                pulse_trig,
  input logic                freq_change,
  input logic                locked,
  input logic                armed,
  input logic [RELOAD_W-1:0] count,
  input logic                wd_en,
  input logic                status
);
  localparam logic [FREQ_W-1:0]   RECOV_L  = RECOV_CODE[FREQ_W-1:0];
  localparam logic [RELOAD_W-1:0] RELOAD_L = RELOAD[RELOAD_W-1:0];

  a_r6_recovery_load: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> (freq_sel == RECOV_L) && locked);

  a_r5_status_set: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> status);

  a_r7_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(freq_sel));

  a_r7_no_change_locked: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !freq_change);

  a_r4_idle_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en |-> (!armed && !locked));

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0) && (count <= RELOAD_L));

  a_r9_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_trig |=> sys_rst_pulse);

  a_r9_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_pulse) |-> $past(pulse_trig));
endmodule

bind fcwd_top fcwd_checks #(
  .FREQ_W(FREQ_W), .RELOAD_W(RELOAD_W), .RELOAD(RELOAD), .RECOV_CODE(RECOV_CODE)
) u_fcwd_checks (
  .clk           (clk),
  .rst_n         (rst_n),
  .freq_sel      (freq_sel),
  .sys_rst_pulse (sys_rst_pulse),
  .timeout_evt   (timeout_evt),
  .pulse_trig    (pulse_trig),
  .freq_change   (freq_change),
  .locked        (locked_q),
  .armed         (armed),
  .count         (count),
  .wd_en         (ctl_q.wd_en),
  .status        (ctl_q.status)
);

// File: tb/fcwd_top_bench.sv
module fcwd_top_bench;
  localparam int RELOAD = 8;
  localparam int RECOV  = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tick = 1'b0;
  logic [3:0] freq_sel;
  logic       sys_rst_pulse;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  fcwd_top #(.FREQ_W(4), .RELOAD(RELOAD), .RECOV_CODE(RECOV)) u_fcwd_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick),
    .freq_sel(freq_sel), .sys_rst_pulse(sys_rst_pulse)
  );

  typedef struct packed {
    logic       we;
    logic       addr;
    logic [7:0] data;
    logic [7:0] ticks;
    logic [3:0] exp_freq;
    logic       exp_status;
    logic       exp_pulse;
  } vec_t;

  // ctl bits: [0] enable, [1] status W1C, [2] reset-on-change
  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 8'h05, 8'd0,  4'd0,  1'b0, 1'b0}, // R10 enable + roc
    '{1'b1, 1'b0, 8'h03, 8'd0,  4'd3,  1'b0, 1'b1}, // R8 change pulses
    '{1'b0, 1'b0, 8'h00, 8'd5,  4'd3,  1'b0, 1'b1}, // R3 count 8->3
    '{1'b1, 1'b0, 8'h03, 8'd2,  4'd3,  1'b0, 1'b1}, // R2 same code, no restart
    '{1'b0, 1'b0, 8'h00, 8'd1,  4'd10, 1'b1, 1'b1}, // R6 timeout at 8th tick
    '{1'b1, 1'b0, 8'h05, 8'd0,  4'd10, 1'b1, 1'b1}, // R7 write ignored
    '{1'b1, 1'b1, 8'h07, 8'd0,  4'd10, 1'b0, 1'b1}, // R5 W1C, still locked
    '{1'b1, 1'b1, 8'h04, 8'd0,  4'd10, 1'b0, 1'b1}, // R4 unlock
    '{1'b1, 1'b0, 8'h05, 8'd0,  4'd5,  1'b0, 1'b1}, // R4 write accepted
    '{1'b0, 1'b0, 8'h00, 8'd20, 4'd5,  1'b0, 1'b0}, // R4 disabled: no timeout
    '{1'b1, 1'b1, 8'h01, 8'd0,  4'd5,  1'b0, 1'b0}, // enable, roc off
    '{1'b1, 1'b0, 8'h06, 8'd6,  4'd6,  1'b0, 1'b0}, // R8 no pulse with roc 0
    '{1'b1, 1'b0, 8'h07, 8'd6,  4'd7,  1'b0, 1'b0}, // R3 restart by new code
    '{1'b0, 1'b0, 8'h00, 8'd2,  4'd10, 1'b1, 1'b1}, // R3 timeout after restart
    '{1'b1, 1'b1, 8'h01, 8'd0,  4'd10, 1'b1, 1'b1}, // R5 write 0 no effect
    '{1'b1, 1'b1, 8'h03, 8'd0,  4'd10, 1'b0, 1'b1}, // R5 clear
    '{1'b1, 1'b0, 8'h02, 8'd0,  4'd10, 1'b0, 1'b1}  // R7 lock survives clear
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 freq", freq_sel, 0);
    chk("R1 pulse", sys_rst_pulse, 0);
    rd(1'b1, r); chk("R1 ctl", r, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].we) wr(VEC[i].addr, VEC[i].data);
      for (int t = 0; t < int'(VEC[i].ticks); t++) begin
        tick = 1'b1; @(posedge clk); @(negedge clk); tick = 1'b0;
      end
      chk($sformatf("R3/R6/R7 v%0d freq", i), freq_sel, VEC[i].exp_freq);
      chk($sformatf("R9 v%0d pulse", i), sys_rst_pulse, VEC[i].exp_pulse);
      rd(1'b1, r);
      chk($sformatf("R5 v%0d status", i), r[1], VEC[i].exp_status);
    end

    // R10 readback of both registers
    wr(1'b1, 8'hFC);
    rd(1'b1, r); chk("R10 ctl upper bits zero", r, 8'h04);
    rd(1'b0, r); chk("R10 freq readback", r, RECOV);

    // R1 second reset returns defaults
    rst_n = 1'b0; @(negedge clk);
    chk("R1 freq after reset", freq_sel, 0);
    rd(1'b1, r); chk("R1 ctl after reset", r, 0);
    rst_n = 1'b1; @(negedge clk);
    repeat (20) @(negedge clk);

    // R9 exact width
    wr(1'b1, 8'h04);
    wr(1'b0, 8'h01);
    n = 0;
    while (sys_rst_pulse && n < 60) begin n++; @(negedge clk); end
    chk("R9 pulse width", n, 16);

    // R2 same code: no pulse
    wr(1'b0, 8'h01);
    chk("R2 same code no pulse", sys_rst_pulse, 0);

    // R9 retrigger
    wr(1'b0, 8'h02);
    repeat (9) @(negedge clk);
    wr(1'b0, 8'h03);
    n = 0;
    while (sys_rst_pulse && n < 60) begin n++; @(negedge clk); end
    chk("R9 retrigger restarts width", n, 16);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule